// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block turns activity on sixteen general-purpose port lines and eight dedicated request pins into interrupt requests. Each input first passes through a two-flop synchronizer. A per-line detector then looks for the kind of activity selected for that line and records it in a pending bit. Port lines can be set to react to any transition or to falling transitions only. Request pins can be set to react while they are held low or on falling transitions only.

Software reaches the block through a single-cycle register port with three 32-bit words: a mode word, a pending word and an enable word. All three use the same bit layout, numbered MSB-first: line index 0 is the most significant bit. Edge-detected pending bits are sticky and are cleared by writing one to them. The block's single interrupt output is raised when any pending bit is set and that bit's enable is also set.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset the mode word, the pending word and the enable word all read zero and `irq` is low. With every input idle high, nothing becomes pending.
- R2: The register port uses address 0 for the mode word, 1 for the pending word and 2 for the enable word. Reads are combinational from `reg_addr`. Address 3 reads zero. In every word, port line k sits at data bit 31-k and request pin j sits at data bit 15-j.
- R3: Data bits 7:0 of every word read as zero, and writes to them are ignored.
- R4: A port line whose mode bit is 0 becomes pending on a rising change and on a falling change of its input. Its pending output is still low two rising clock edges after the input changes and is set after the third.
- R5: A port line whose mode bit is 1 becomes pending only on a high-to-low change. A low-to-high change leaves it clear.
- R6: A request pin whose mode bit is 0 shows pending two clock edges after the pin goes low. It stays pending while the pin is low, even when software writes one to clear it. It drops two edges after the pin returns high.
- R7: A request pin whose mode bit is 1 becomes pending on a high-to-low change and stays pending after the pin returns high. A low-to-high change leaves it clear.
- R8: Writing the pending word clears exactly the edge-detected pending bits written as one. Bits written as zero keep their state.
- R9: When an edge is detected in the same cycle that a write clears that line's pending bit, the bit stays set.
- R10: Changing a mode bit never creates a pending event by itself. An input held steady through a mode change does not become pending.
- R11: `irq` is high exactly when some pending bit has its enable bit set in the enable word, which resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_in | input | 16 | Asynchronous general-purpose port lines, idle high |
| pin_in | input | 8 | Asynchronous request pins, idle high |
| reg_addr | input | 2 | Word select: 0 mode, 1 pending, 2 enable |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| port_pend | output | 16 | Pending state of each port line |
| pin_pend | output | 8 | Pending state of each request pin |
| irq | output | 1 | Combined request: OR of pending bits that are enabled |

## Verification
Two things can fall in the same cycle: an edge that sets a pending bit, and a software write that clears that same bit. The bench provokes the collision by toggling a port line that is already pending. It counts two clock edges for the synchronizer and then issues the clear write, so the write lands on the edge where the detector fires. The bit must then remain set. A later clear with no edge present must drop it, which shows that the write did take effect and lost only the collision.

// File: rtl/eid_pkg.sv
// Shared definitions for the external interrupt detector.
// Assumes a two-bit word select on the register port.
package eid_pkg;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_PEND = 2'd1,
        REG_MASK = 2'd2,
        REG_NONE = 2'd3
    } eid_reg_e;

endpackage

// File: rtl/eid_sync.sv
// Multi-stage input synchronizer with an extra previous-sample register.
// Assumes every bit is independent and idles at RST_VAL; q_prev lags q by
// one cycle and keeps tracking whatever the detection mode is.
module eid_sync #(
    parameter int   W       = 16,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] stg [STAGES];

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= {W{RST_VAL}};
            end
            q_prev <= {W{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
            q_prev <= stg[STAGES-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/eid_cell.sv
// Detector and pending latch for one line.
// IS_PIN = 0: port line, mode 0 any change, mode 1 falling edge.
// IS_PIN = 1: request pin, mode 0 low level, mode 1 falling edge.
// Assumes s and prev are synchronized samples one cycle apart.
module eid_cell #(
    parameter bit IS_PIN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s,
    input  logic prev,
    input  logic mode,
    input  logic clr,
    output logic pend
);

    logic evt;
    logic held_q;

    generate
        if (IS_PIN) begin : g_pin
            // Request pin: only the falling-edge mode produces events.
            always_comb evt = mode & prev & ~s;
            // Level mode shows the inverted pin; edge mode shows the latch.
            always_comb pend = mode ? held_q : ~s;
        end else begin : g_port
            // Port line: falling edge only, or any change.
            always_comb evt = mode ? (prev & ~s) : (prev ^ s);
            // Port lines always report the sticky latch.
            always_comb pend = held_q;
        end
    endgenerate

    // Sticky latch: set by an event, cleared by a write; the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= (held_q & ~clr) | evt;
    end

endmodule

// File: rtl/eid_regs.sv
// Mode and enable words, the pending clear strobe and the read mux.
// Assumes the live lines occupy the top N_LINE bits of each word and the
// bits below them are reserved.
module eid_regs
    import eid_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_LINE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pend_word,
    output logic [DATA_W-1:0] mode_word,
    output logic [DATA_W-1:0] mask_word,
    output logic [DATA_W-1:0] clr_word,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] LIVE = {{N_LINE{1'b1}}, {(DATA_W-N_LINE){1'b0}}};

    eid_reg_e sel;
    assign sel = eid_reg_e'(addr);

    // Mode word: written in full, reserved bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                     mode_word <= '0;
        else if (wr && sel == REG_MODE) mode_word <= wdata & LIVE;
    end

    // Enable word: same handling as the mode word.
    always_ff @(posedge clk) begin
        if (!rst_n)                     mask_word <= '0;
        else if (wr && sel == REG_MASK) mask_word <= wdata & LIVE;
    end

    // Write-one-to-clear strobe towards the line cells.
    always_comb clr_word = (wr && sel == REG_PEND) ? (wdata & LIVE) : '0;

    // Combinational read of the selected word.
    always_comb begin
        unique case (sel)
            REG_MODE: rdata = mode_word;
            REG_PEND: rdata = pend_word & LIVE;
            REG_MASK: rdata = mask_word;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ext_irq_detect.sv
// Top of the external interrupt detector: synchronizers, one detector cell
// per line, register words and the combined request.
// Assumes inputs idle high; line k of the ports maps to word bit DATA_W-1-k,
// pin j maps to word bit DATA_W-1-N_PORT-j.
module ext_irq_detect #(
    parameter int N_PORT = 16,
    parameter int N_PIN  = 8,
    parameter int DATA_W = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PORT-1:0] port_in,
    input  logic [N_PIN-1:0]  pin_in,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_PORT-1:0] port_pend,
    output logic [N_PIN-1:0]  pin_pend,
    output logic              irq
);

    localparam int N_LINE = N_PORT + N_PIN;
    localparam int N_RSV  = DATA_W - N_LINE;

    logic [N_PORT-1:0] port_s, port_prev;
    logic [N_PIN-1:0]  pin_s, pin_prev;
    logic [DATA_W-1:0] mode_word, mask_word, clr_word, pend_word;

    eid_sync #(.W(N_PORT), .STAGES(STAGES), .RST_VAL(1'b1)) u_port_sync (
        .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s), .q_prev(port_prev)
    );

    eid_sync #(.W(N_PIN), .STAGES(STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s), .q_prev(pin_prev)
    );

    generate
        for (genvar k = 0; k < N_PORT; k++) begin : g_port
            localparam int B = DATA_W - 1 - k;
            eid_cell #(.IS_PIN(1'b0)) u_cell (
                .clk(clk), .rst_n(rst_n), .s(port_s[k]), .prev(port_prev[k]),
                .mode(mode_word[B]), .clr(clr_word[B]), .pend(port_pend[k])
            );
            assign pend_word[B] = port_pend[k];
        end
        for (genvar j = 0; j < N_PIN; j++) begin : g_pin
            localparam int B = DATA_W - 1 - N_PORT - j;
            eid_cell #(.IS_PIN(1'b1)) u_cell (
                .clk(clk), .rst_n(rst_n), .s(pin_s[j]), .prev(pin_prev[j]),
                .mode(mode_word[B]), .clr(clr_word[B]), .pend(pin_pend[j])
            );
            assign pend_word[B] = pin_pend[j];
        end
        for (genvar r = 0; r < N_RSV; r++) begin : g_rsv
            assign pend_word[r] = 1'b0;
        end
    endgenerate

    eid_regs #(.DATA_W(DATA_W), .N_LINE(N_LINE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .pend_word(pend_word), .mode_word(mode_word),
        .mask_word(mask_word), .clr_word(clr_word), .rdata(reg_rdata)
    );

    // Combined request from enabled pending bits.
    always_comb irq = |(pend_word & mask_word);

endmodule

// File: rtl/eid_checker.sv
// Property checker for ext_irq_detect, attached through bind.
// Assumes the same word layout as the design it observes.
module eid_checker #(
    parameter int N_PORT = 16,
    parameter int N_PIN  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] mode_word,
    input logic [DATA_W-1:0] mask_word,
    input logic [N_PORT-1:0] port_s,
    input logic [N_PORT-1:0] port_prev,
    input logic [N_PIN-1:0]  pin_s,
    input logic [N_PORT-1:0] port_pend,
    input logic [N_PIN-1:0]  pin_pend,
    input logic              irq
);

    localparam int N_LINE = N_PORT + N_PIN;

    logic [N_PORT-1:0] port_clr;
    logic [N_PIN-1:0]  pin_level;

    // Decode the clear strobe and the level-mode pins independently.
    always_comb begin
        for (int k = 0; k < N_PORT; k++)
            port_clr[k] = reg_wr && (reg_addr == 2'd1) && reg_wdata[DATA_W-1-k];
        for (int j = 0; j < N_PIN; j++)
            pin_level[j] = ~mode_word[DATA_W-1-N_PORT-j];
    end

    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[DATA_W-N_LINE-1:0] == '0)); // R3

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_pend ^ ~pin_s) & pin_level) == '0)); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((port_pend & $past(port_pend & ~port_clr)) == $past(port_pend & ~port_clr))); // R8

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((port_pend & ~$past(port_pend) & ~$past(port_s ^ port_prev)) == '0)); // R10

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_word == '0) |-> !irq); // R11

endmodule

bind ext_irq_detect eid_checker #(.N_PORT(N_PORT), .N_PIN(N_PIN), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_word(mode_word),
    .mask_word(mask_word), .port_s(port_s), .port_prev(port_prev),
    .pin_s(pin_s), .port_pend(port_pend), .pin_pend(pin_pend), .irq(irq)
);

// File: tb/sim_ext_irq_detect.sv
`timescale 1ns/1ps
// Directed bench for ext_irq_detect; every scenario task checks itself.
module sim_ext_irq_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] port_in = '1;
    logic [7:0]  pin_in = '1;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] port_pend;
    logic [7:0]  pin_pend;
    logic        irq;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_detect u0 (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .pin_in(pin_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .port_pend(port_pend), .pin_pend(pin_pend),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic idle_clear();
        port_in = '1; pin_in = '1;
        step(4);
        wr(2'd1, 32'hFFFF_FFFF);
        step(1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1 mode", d, 0);
        rd(2'd1, d); chk("R1 pend", d, 0);
        rd(2'd2, d); chk("R1 enable", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        step(4);
        chk("R1 idle port", {16'd0, port_pend}, 0);
        chk("R1 idle pin", {24'd0, pin_pend}, 0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R3 reserved mode bits", d, 32'hFFFF_FF00);
        wr(2'd2, 32'h0000_00FF);
        rd(2'd2, d); chk("R3 reserved enable bits", d, 0);
        rd(2'd3, d); chk("R2 address 3 reads zero", d, 0);
        wr(2'd0, 32'h1000_0400);   // port 3 (bit 28), pin 5 (bit 10)
        rd(2'd0, d); chk("R2 mode readback", d, 32'h1000_0400);
        idle_clear();
    endtask

    task automatic t_port_any();
        logic [31:0] d;
        wr(2'd0, 32'h0);
        port_in[0] = 1'b0;          // falling change
        step(2); chk("R4 not yet after two edges", {16'd0, port_pend}, 0);
        step(1); chk("R4 falling sets", {16'd0, port_pend}, 32'h1);
        rd(2'd1, d); chk("R2 port0 at bit31", d, 32'h8000_0000);
        wr(2'd1, 32'h8000_0000);
        chk("R8 clear", {16'd0, port_pend}, 0);
        port_in[0] = 1'b1;          // rising change
        step(3); chk("R4 rising sets", {16'd0, port_pend}, 32'h1);
        idle_clear();
    endtask

    task automatic t_port_fall();
        wr(2'd0, 32'h1000_0000);    // port 3 falling only, port 4 any
        port_in[3] = 1'b0; port_in[4] = 1'b0;
        step(3); chk("R5 falling sets port3 and port4", {16'd0, port_pend}, 32'h18);
        wr(2'd1, 32'h1800_0000);
        port_in[3] = 1'b1; port_in[4] = 1'b1;
        step(4); chk("R5 rising only sets any-change port4", {16'd0, port_pend}, 32'h10);
        idle_clear();
    endtask

    task automatic t_pin_level();
        logic [31:0] d;
        wr(2'd0, 32'h0);
        pin_in[2] = 1'b0;
        step(1); chk("R6 not yet", {24'd0, pin_pend}, 0);
        step(1); chk("R6 low asserts", {24'd0, pin_pend}, 32'h4);
        rd(2'd1, d); chk("R2 pin2 at bit13", d, 32'h0000_2000);
        wr(2'd1, 32'h0000_2000);
        chk("R6 clear ignored while low", {24'd0, pin_pend}, 32'h4);
        pin_in[2] = 1'b1;
        step(2); chk("R6 drops when high", {24'd0, pin_pend}, 0);
        idle_clear();
    endtask

    task automatic t_pin_edge();
        wr(2'd0, 32'h0000_0400);    // pin 5 falling edge
        pin_in[5] = 1'b0;
        step(3); chk("R7 falling sets", {24'd0, pin_pend}, 32'h20);
        pin_in[5] = 1'b1;
        step(4); chk("R7 sticky after release", {24'd0, pin_pend}, 32'h20);
        wr(2'd1, 32'h0000_0400);
        chk("R7 clear", {24'd0, pin_pend}, 0);
        idle_clear();
    endtask

    task automatic t_w1c();
        wr(2'd0, 32'h0);
        port_in[0] = 1'b0; port_in[1] = 1'b0;
        step(3);
        wr(2'd1, 32'h0);
        chk("R8 zero write keeps", {16'd0, port_pend}, 32'h3);
        wr(2'd1, 32'h4000_0000);
        chk("R8 only port1 cleared", {16'd0, port_pend}, 32'h1);
        idle_clear();
    endtask

    task automatic t_collide();
        wr(2'd0, 32'h0);
        port_in[0] = 1'b0;
        step(3); chk("R9 setup pending", {16'd0, port_pend}, 32'h1);
        port_in[0] = 1'b1;
        step(2);                    // detector fires on the next edge
        wr(2'd1, 32'h8000_0000);    // clear lands on that same edge
        chk("R9 edge beats clear", {16'd0, port_pend}, 32'h1);
        wr(2'd1, 32'h8000_0000);
        chk("R9 later clear works", {16'd0, port_pend}, 0);
        idle_clear();
    endtask

    task automatic t_mode_switch();
        wr(2'd0, 32'h0);
        port_in[6] = 1'b0; pin_in[1] = 1'b0;
        step(4);
        wr(2'd1, 32'hFFFF_FFFF);
        chk("R10 port6 cleared", {16'd0, port_pend}, 0);
        chk("R10 pin1 level", {24'd0, pin_pend}, 32'h2);
        wr(2'd0, 32'h0200_4000);    // port 6 bit 25, pin 1 bit 14
        step(4);
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h0200_4000);
        step(4);
        chk("R10 port6 no event", {16'd0, port_pend}, 0);
        chk("R10 pin1 no event", {24'd0, pin_pend}, 0);
        wr(2'd0, 32'h0);
        idle_clear();
    endtask

    task automatic t_irq();
        wr(2'd0, 32'h0);
        port_in[2] = 1'b0;
        step(3);
        chk("R11 masked", {31'd0, irq}, 0);
        wr(2'd2, 32'h4000_0000);    // enable port 1 only
        chk("R11 other enable", {31'd0, irq}, 0);
        wr(2'd2, 32'h2000_0000);    // enable port 2
        chk("R11 enabled", {31'd0, irq}, 1);
        wr(2'd1, 32'h2000_0000);
        chk("R11 cleared", {31'd0, irq}, 0);
        wr(2'd2, 32'h0);
        idle_clear();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_layout();
        t_port_any();
        t_port_fall();
        t_pin_level();
        t_pin_edge();
        t_w1c();
        t_collide();
        t_mode_switch();
        t_irq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule